// File: doc/BRIEF.md
# DRAM Data Pin Driver Control

This block models the data-pin behaviour of an asynchronous page-mode DRAM with a 16-bit data bus. A system clock samples the four active-low strobes: row strobe, column strobe, write enable and output enable. The block compares each sample with the previous one to find strobe edges. From the order of those edges it classifies the cycle in progress and decides whether the data pins drive array data, keep driving latched data, or float.

A small storage array supplies read data. The row address is taken when the row strobe falls and the column address when the column strobe falls, both from the same multiplexed address input. An output latch keeps the last word read. The driver enable and the latch are registered, so a strobe change is seen on the pins at the clock edge that samples it. The classified cycle type is also brought out as a 3-bit code so that the surrounding model can observe it.

Top module: `dram_dout_ctrl`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `dq_oe` is 0, `dq_out` is 0 and `cyc_kind` is 0 (idle). The stored array contents are not cleared.
- R2: A column-strobe fall with the row strobe low and write enable high is a read. At that sample `dq_out` takes the cell at {row, column}, `cyc_kind` becomes 1 and `dq_oe` equals the inverse of `oe_n`. Each further column-strobe fall within the same row cycle reads a new column (page mode).
- R3: A column-strobe rise while the row strobe stays low turns the drivers off at that sample. `dq_out` keeps its value.
- R4: Write enable low at a column-strobe fall is an early write. The cell is written with `din`, `cyc_kind` becomes 2, and `dq_oe` stays 0 for the rest of the column cycle, whatever `oe_n` does.
- R5: Write enable falling while the column strobe was already low is a late write or read-modify-write. The cell at the latched address is written with `din` and `cyc_kind` becomes 3. `dq_out` keeps the read data, and the driver keeps its state, so `oe_n` alone decides whether it drives.
- R6: `oe_n` high gives `dq_oe` = 0 at that sample, and `dq_out` is not changed. Taking `oe_n` low again re-enables the driver when the cycle allows driving.
- R7: A row-strobe fall with the column strobe high starts an access. `cyc_kind` becomes 4 (RAS-only refresh until a column strobe arrives), and the drivers are off.
- R8: A row-strobe fall with the column strobe already low is a CAS-before-RAS refresh. `cyc_kind` becomes 5, and `dq_oe` and `dq_out` keep their previous values, including after that refresh cycle ends. This covers hidden refresh after a read.
- R9: A column-strobe fall with the row strobe high sets `cyc_kind` to 6. If the column strobe rises again without a row strobe, the drivers turn off.
- R10: The first sample with both row and column strobes high ends the cycle. `cyc_kind` returns to 0, and `dq_oe` goes to 0 unless the ending cycle was a CAS-before-RAS refresh.
- R11: Row and column strobes falling on the same sample count as row first. Row and column both come from that sample's address, and the access proceeds as a read (R2) or an early write (R4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (3) | Multiplexed row/column address |
| din | input | DATA_W (16) | Write data |
| dq_out | output | DATA_W (16) | Output latch contents shown on the data pins |
| dq_oe | output | 1 | Data pin driver enable (0 = high impedance) |
| cyc_kind | output | 3 | Cycle type code: 0 idle, 1 read, 2 early write, 3 late write/RMW, 4 RAS-only, 5 CAS-before-RAS, 6 CAS-only |

## Verification
The row-cycle start and the column access can land on the same sample when both strobes fall between two clock edges. The bench provokes this twice. First it does a combined fall with write enable low, which must write the cell addressed by the single address at {addr, addr}. Then it does a combined fall with write enable high, which must drive that written word with `cyc_kind` = 1. If the row capture and the column decode were ordered wrongly, the second access would read a different cell or would be classified as a refresh.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  typedef enum logic [2:0] {
    KIND_IDLE    = 3'd0,
    KIND_READ    = 3'd1,
    KIND_EARLY_W = 3'd2,
    KIND_LATE_W  = 3'd3,
    KIND_ROW_REF = 3'd4,
    KIND_CBR     = 3'd5,
    KIND_COL_ONLY = 3'd6
  } kind_t;

  typedef enum logic [1:0] {
    MODE_IDLE,
    MODE_ACCESS,
    MODE_CBR,
    MODE_COL_FIRST
  } mode_t;

  localparam int STROBES = 3;
  localparam int S_RAS   = 2;
  localparam int S_CAS   = 1;
  localparam int S_WE    = 0;

endpackage

// File: rtl/ddc_strobe_edge.sv
module ddc_strobe_edge
  import ddc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STROBES-1:0] strb_n,
  output logic [STROBES-1:0] fall,
  output logic [STROBES-1:0] rise,
  output logic [STROBES-1:0] prev_n,
  output logic               cycle_end
);

  genvar g;
  generate
    for (g = 0; g < STROBES; g++) begin : g_strobe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_n[g] <= 1'b1;
        else        prev_n[g] <= strb_n[g];
      end
      assign fall[g] = prev_n[g] & ~strb_n[g];
      assign rise[g] = ~prev_n[g] & strb_n[g];
    end
  endgenerate

  assign cycle_end = strb_n[S_RAS] & strb_n[S_CAS] &
                     ~(prev_n[S_RAS] & prev_n[S_CAS]);

endmodule

// File: rtl/ddc_cycle_fsm.sv
module ddc_cycle_fsm
  import ddc_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int IDX_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras_fall,
  input  logic              cas_fall,
  input  logic              cas_rise,
  input  logic              we_fall,
  input  logic              cas_was_low,
  input  logic              cycle_end,
  output logic              drive_nxt,
  output kind_t             kind_q,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx
);

  mode_t             mode_q, mode_nxt;
  kind_t             kind_nxt;
  logic              drive_q;
  logic              early_q, early_nxt;
  logic [ADDR_W-1:0] row_q, row_nxt, col_q, col_nxt, row_sel;

  assign row_sel = ras_fall ? addr : row_q;

  always_comb begin
    mode_nxt  = mode_q;
    kind_nxt  = kind_q;
    drive_nxt = drive_q;
    early_nxt = early_q;
    row_nxt   = row_q;
    col_nxt   = col_q;
    rd_en     = 1'b0;
    wr_en     = 1'b0;
    rd_idx    = {row_sel, addr};
    wr_idx    = {row_q, col_q};

    if (cycle_end) begin
      mode_nxt = MODE_IDLE;
      kind_nxt = KIND_IDLE;
      if (mode_q != MODE_CBR) drive_nxt = 1'b0;
    end else begin
      if (ras_fall) begin
        if (!cas_n && cas_was_low) begin
          mode_nxt = MODE_CBR;
          kind_nxt = KIND_CBR;
        end else begin
          mode_nxt  = MODE_ACCESS;
          kind_nxt  = KIND_ROW_REF;
          drive_nxt = 1'b0;
          row_nxt   = addr;
        end
      end

      if (cas_fall && !ras_n && mode_nxt == MODE_ACCESS) begin
        col_nxt = addr;
        if (!we_n) begin
          wr_en     = 1'b1;
          wr_idx    = {row_sel, addr};
          kind_nxt  = KIND_EARLY_W;
          drive_nxt = 1'b0;
          early_nxt = 1'b1;
        end else begin
          rd_en     = 1'b1;
          kind_nxt  = KIND_READ;
          drive_nxt = 1'b1;
          early_nxt = 1'b0;
        end
      end else if (cas_fall && ras_n) begin
        mode_nxt = MODE_COL_FIRST;
        kind_nxt = KIND_COL_ONLY;
      end

      if (cas_rise && !ras_n && mode_q == MODE_ACCESS)
        drive_nxt = 1'b0;

      if (we_fall && !cas_n && cas_was_low && !ras_n &&
          mode_q == MODE_ACCESS && !early_q) begin
        wr_en    = 1'b1;
        wr_idx   = {row_q, col_q};
        kind_nxt = KIND_LATE_W;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_IDLE;
      kind_q  <= KIND_IDLE;
      drive_q <= 1'b0;
      early_q <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      mode_q  <= mode_nxt;
      kind_q  <= kind_nxt;
      drive_q <= drive_nxt;
      early_q <= early_nxt;
      row_q   <= row_nxt;
      col_q   <= col_nxt;
    end
  end

endmodule

// File: rtl/ddc_cell_array.sv
module ddc_cell_array #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  assign rd_data = cells[rd_idx];

endmodule

// File: rtl/ddc_out_stage.sv
module ddc_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_nxt,
  input  logic              oe_n,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      if (rd_en) dq_out <= rd_data;
      dq_oe <= drive_nxt & ~oe_n;
    end
  end

endmodule

// File: rtl/dram_dout_ctrl.sv
module dram_dout_ctrl
  import ddc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [2:0]        cyc_kind
);

  localparam int IDX_W = 2 * ADDR_W;

  logic [STROBES-1:0] strb_n, fall, rise, prev_n;
  logic               cycle_end, drive_nxt, rd_en, wr_en;
  logic [IDX_W-1:0]   rd_idx, wr_idx;
  logic [DATA_W-1:0]  rd_data;
  kind_t              kind_q;

  assign strb_n[S_RAS] = ras_n;
  assign strb_n[S_CAS] = cas_n;
  assign strb_n[S_WE]  = we_n;

  ddc_strobe_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb_n    (strb_n),
    .fall      (fall),
    .rise      (rise),
    .prev_n    (prev_n),
    .cycle_end (cycle_end)
  );

  ddc_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .addr        (addr),
    .ras_fall    (fall[S_RAS]),
    .cas_fall    (fall[S_CAS]),
    .cas_rise    (rise[S_CAS]),
    .we_fall     (fall[S_WE]),
    .cas_was_low (~prev_n[S_CAS]),
    .cycle_end   (cycle_end),
    .drive_nxt   (drive_nxt),
    .kind_q      (kind_q),
    .rd_en       (rd_en),
    .rd_idx      (rd_idx),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx)
  );

  ddc_cell_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cells (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (din),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  ddc_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_nxt (drive_nxt),
    .oe_n      (oe_n),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  assign cyc_kind = kind_q;

  logic unused_rise;
  assign unused_rise = rise[S_RAS] | rise[S_WE] | prev_n[S_RAS] | prev_n[S_WE];

endmodule

// File: rtl/ddc_checker.sv
module ddc_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic [2:0]        cyc_kind
);

  logic p_ras, p_cas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ras <= 1'b1;
      p_cas <= 1'b1;
    end else begin
      p_ras <= ras_n;
      p_cas <= cas_n;
    end
  end

  assert_oe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dq_oe);

  assert_early_wr_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (p_cas && !cas_n && !ras_n && !we_n) |=> !dq_oe);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (p_cas && !cas_n && !ras_n && we_n && !oe_n && cyc_kind != 3'd5)
      |=> (dq_oe && cyc_kind == 3'd1));

  assert_ras_only_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (p_ras && !ras_n && cas_n) |=> !dq_oe);

  assert_end_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n && !(p_ras && p_cas) && cyc_kind != 3'd5) |=> !dq_oe);

  assert_cbr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd5) |=> $stable(dq_out));

endmodule

bind dram_dout_ctrl ddc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe),
  .cyc_kind (cyc_kind)
);

// File: tb/dram_dout_ctrl_test.sv
`timescale 1ns/1ps
module dram_dout_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [2:0]  cyc_kind;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_dout_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
    .cyc_kind(cyc_kind)
  );

  // strobes {ras,cas,we,oe}, addr, din, exp oe, exp out, exp kind, requirement
  localparam int NV = 39;
  localparam logic [46:0] TBL [NV] = '{
    {4'b1111, 3'd0, 16'h0000, 1'b0, 16'h0000, 3'd0, 4'd1},  // R1 idle after reset
    {4'b0111, 3'd2, 16'h0000, 1'b0, 16'h0000, 3'd4, 4'd7},  // R7 row open
    {4'b0101, 3'd2, 16'h0000, 1'b0, 16'h0000, 3'd4, 4'd7},
    {4'b0000, 3'd5, 16'hA5A5, 1'b0, 16'h0000, 3'd2, 4'd4},  // R4 early write, OE low
    {4'b0110, 3'd5, 16'h0000, 1'b0, 16'h0000, 3'd2, 4'd4},
    {4'b1110, 3'd0, 16'h0000, 1'b0, 16'h0000, 3'd0, 4'd10}, // R10
    {4'b0110, 3'd2, 16'h0000, 1'b0, 16'h0000, 3'd4, 4'd7},
    {4'b0010, 3'd5, 16'h0000, 1'b1, 16'hA5A5, 3'd1, 4'd2},  // R2 read
    {4'b0011, 3'd5, 16'h0000, 1'b0, 16'hA5A5, 3'd1, 4'd6},  // R6 OE high
    {4'b0010, 3'd5, 16'h0000, 1'b1, 16'hA5A5, 3'd1, 4'd6},  // R6 OE low again
    {4'b0110, 3'd5, 16'h0000, 1'b0, 16'hA5A5, 3'd1, 4'd3},  // R3 CAS rise
    {4'b0100, 3'd5, 16'h0000, 1'b0, 16'hA5A5, 3'd1, 4'd3},
    {4'b0000, 3'd6, 16'h1234, 1'b0, 16'hA5A5, 3'd2, 4'd4},  // R4 page early write
    {4'b0110, 3'd6, 16'h0000, 1'b0, 16'hA5A5, 3'd2, 4'd3},
    {4'b0010, 3'd6, 16'h0000, 1'b1, 16'h1234, 3'd1, 4'd2},  // R2 page read
    {4'b0000, 3'd6, 16'hBEEF, 1'b1, 16'h1234, 3'd3, 4'd5},  // R5 RMW, OE low
    {4'b1110, 3'd0, 16'h0000, 1'b0, 16'h1234, 3'd0, 4'd10},
    {4'b0110, 3'd2, 16'h0000, 1'b0, 16'h1234, 3'd4, 4'd7},
    {4'b0010, 3'd6, 16'h0000, 1'b1, 16'hBEEF, 3'd1, 4'd5},  // R5 written word read back
    {4'b0011, 3'd6, 16'h0000, 1'b0, 16'hBEEF, 3'd1, 4'd6},
    {4'b0001, 3'd6, 16'h0F0F, 1'b0, 16'hBEEF, 3'd3, 4'd5},  // R5 late write, OE high
    {4'b1111, 3'd0, 16'h0000, 1'b0, 16'hBEEF, 3'd0, 4'd10},
    {4'b0110, 3'd2, 16'h0000, 1'b0, 16'hBEEF, 3'd4, 4'd7},
    {4'b0010, 3'd6, 16'h0000, 1'b1, 16'h0F0F, 3'd1, 4'd2},
    {4'b1010, 3'd6, 16'h0000, 1'b1, 16'h0F0F, 3'd1, 4'd8},  // R8 hidden refresh
    {4'b0010, 3'd6, 16'h0000, 1'b1, 16'h0F0F, 3'd5, 4'd8},
    {4'b1110, 3'd0, 16'h0000, 1'b1, 16'h0F0F, 3'd0, 4'd8},
    {4'b1110, 3'd0, 16'h0000, 1'b1, 16'h0F0F, 3'd0, 4'd10},
    {4'b1010, 3'd0, 16'h0000, 1'b1, 16'h0F0F, 3'd6, 4'd9},  // R9 CAS only
    {4'b1110, 3'd0, 16'h0000, 1'b0, 16'h0F0F, 3'd0, 4'd9},
    {4'b1010, 3'd0, 16'h0000, 1'b0, 16'h0F0F, 3'd6, 4'd9},
    {4'b0010, 3'd0, 16'h0000, 1'b0, 16'h0F0F, 3'd5, 4'd8},  // R8 plain refresh
    {4'b1110, 3'd0, 16'h0000, 1'b0, 16'h0F0F, 3'd0, 4'd8},
    {4'b0110, 3'd1, 16'h0000, 1'b0, 16'h0F0F, 3'd4, 4'd7},
    {4'b1110, 3'd0, 16'h0000, 1'b0, 16'h0F0F, 3'd0, 4'd10},
    {4'b0000, 3'd3, 16'h5555, 1'b0, 16'h0F0F, 3'd2, 4'd11}, // R11 joint fall, write
    {4'b1110, 3'd0, 16'h0000, 1'b0, 16'h0F0F, 3'd0, 4'd10},
    {4'b0010, 3'd3, 16'h0000, 1'b1, 16'h5555, 3'd1, 4'd11}, // R11 joint fall, read
    {4'b1110, 3'd0, 16'h0000, 1'b0, 16'h5555, 3'd0, 4'd10}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] s, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    {ras_n, cas_n, we_n, oe_n} = s;
    addr = a;
    din  = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 oe in reset", {15'd0, dq_oe}, 16'd0);
    chk("R1 out in reset", dq_out, 16'd0);
    chk("R1 kind in reset", {13'd0, cyc_kind}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      string t;
      v = TBL[i];
      drive(v[46:43], v[42:40], v[39:24]);
      t = $sformatf("R%0d step %0d", v[3:0], i);
      chk({t, " oe"}, {15'd0, dq_oe}, {15'd0, v[23]});
      chk({t, " out"}, dq_out, v[22:7]);
      chk({t, " kind"}, {13'd0, cyc_kind}, {13'd0, v[6:4]});
    end

    // R1: reset in the middle of a driving read clears the pins, keeps cells
    drive(4'b0110, 3'd3, 16'h0);
    drive(4'b0010, 3'd3, 16'h0);
    chk("R1 pre-reset drive", {15'd0, dq_oe}, 16'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async oe", {15'd0, dq_oe}, 16'd0);
    chk("R1 async out", dq_out, 16'd0);
    chk("R1 async kind", {13'd0, cyc_kind}, 16'd0);
    {ras_n, cas_n, we_n, oe_n} = 4'b1110;
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'b1110, 3'd0, 16'h0);
    drive(4'b0110, 3'd3, 16'h0);
    drive(4'b0010, 3'd3, 16'h0);
    chk("R1 cells kept over reset", dq_out, 16'h5555);
    // R6: OE raised while in late-write state, then lowered restores drive
    drive(4'b0000, 3'd3, 16'h7777);
    chk("R5 late write keeps data", dq_out, 16'h5555);
    drive(4'b0001, 3'd3, 16'h0);
    chk("R6 oe high", {15'd0, dq_oe}, 16'd0);
    drive(4'b0000, 3'd3, 16'h0);
    chk("R6 oe low restores", {15'd0, dq_oe}, 16'd1);
    drive(4'b1110, 3'd0, 16'h0);
    chk("R10 end float", {15'd0, dq_oe}, 16'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule